// File: doc/BRIEF.md
# Shared-Function I/O Pin Controller

This block arbitrates 32 chip pins, each of which serves either a dedicated on-chip peripheral or software as a general-purpose I/O (PIO). For every pin, three register bits set its use: a mode bit (1 = PIO, 0 = peripheral), a direction bit (1 = output, 0 = input) and a pull bit (1 = weak pull-up, 0 = weak pull-down). The block drives the pad's output value and output enable and two pull-select lines. It also hands the raw pad level to the peripheral, and it returns a synchronized copy of all pad levels through a small register read port.

Reset values come from three per-pin parameters, so each pin starts in its own configuration. A small lifecycle machine has two states. `ST_BOOT` is entered while reset is asserted and lasts for the first clock edge after reset is released. On that edge the boot strap is latched, the machine takes the transition `boot_done` to `ST_ACTIVE`, and it then stays there through the transition `hold_active` until the next reset. If the strap is low at that edge, a parameterized set of pins is locked to its peripheral function until the next reset. While bus hold or test isolation is requested, the bus-status pins stop driving whenever they are in peripheral use.

Top module: `pio_shared_ctrl`

## Requirements
- R1: After reset, registers read back as MODE_RST=0x2000FFC0, DIR_RST=0x00000F00 and PULL_RST=0x200000C0, and the data register reads 0. Address 0 is mode, 1 is direction, 2 is data and 3 is pull.
- R2: Pin 29 leaves reset as a PIO input with pull-up: pad_oe_o[29]=0, pull_up_o[29]=1, pull_dn_o[29]=0.
- R3: A pin with mode bit 0 drives pad_out_o and pad_oe_o from periph_out_i and periph_oe_i. Pins 0 to 5, which are boot-critical, are in this mode after reset.
- R4: A pin with mode 1 and direction 1 drives pad_out_o from the data register bit and asserts pad_oe_o.
- R5: A pin with mode 1 and direction 0 has pad_oe_o=0 and asserts pull_up_o if its pull bit is 1, or pull_dn_o if it is 0. A pin in any other configuration asserts neither pull line, and no pin ever asserts both.
- R6: Address 4 reads the pad levels through a two-stage synchronizer. A pad change that is set up before clock edge k reads back after edge k+1 and not after edge k.
- R7: If strap_i is low at the first edge after reset, pins 14 and 31 (LOCK_MASK=0x80004000) read mode 0 and stay in peripheral use. Writes to the mode register cannot set their bits, writes to the direction register leave their bits unchanged, and later changes of strap_i have no effect until reset.
- R8: If strap_i is high at that edge, every pin, including pins 14 and 31, keeps its mode default and accepts mode writes.
- R9: While hold_i or isolate_i is high, pins 16 to 18 (ISO_MASK=0x00070000) in peripheral mode have pad_oe_o=0. Other pins are unaffected.
- R10: The first clock edge after reset is the boot edge (`ST_BOOT`), and a write presented on it is ignored.
- R11: Writes to address 4 and to addresses 5 to 7 change no register, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Boot strap, latched on the boot edge; low locks LOCK_MASK pins |
| hold_i | input | 1 | Bus hold request; floats bus-status pins |
| isolate_i | input | 1 | Test isolation request; floats bus-status pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| periph_out_i | input | 32 | Peripheral output values per pin |
| periph_oe_i | input | 32 | Peripheral output enables per pin |
| periph_in_o | output | 32 | Raw pad levels to the peripherals |
| pad_in_i | input | 32 | Pad input levels |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| pull_up_o | output | 32 | Weak pull-up select per pin |
| pull_dn_o | output | 32 | Weak pull-down select per pin |

## Verification
The bench goes after the strap lock. Its tests write all ones to mode and direction after a low strap and later flip the strap. A design that masked only the mode write, or that kept sampling the strap, would hand pins 14 or 31 to software or corrupt their direction bit. It holds a write across reset release to catch a design that accepts writes on the boot edge, and it samples the synchronized level one edge early and one edge late to catch a synchronizer with the wrong depth. It raises hold and isolate separately to catch a float gated by only one of them, or one that spills onto pins outside the bus-status set.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [2:0] {
        REG_MODE  = 3'd0,
        REG_DIR   = 3'd1,
        REG_DATA  = 3'd2,
        REG_PULL  = 3'd3,
        REG_LEVEL = 3'd4,
        REG_RSV5  = 3'd5,
        REG_RSV6  = 3'd6,
        REG_RSV7  = 3'd7
    } reg_sel_e;

    typedef enum logic [0:0] {
        ST_BOOT   = 1'b0,
        ST_ACTIVE = 1'b1
    } life_st_e;

endpackage

// File: rtl/pio_life_fsm.sv
module pio_life_fsm
    import pio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    output life_st_e state_o,
    output logic     boot_cycle_o,
    output logic     wr_allow_o
);

    life_st_e state_q;
    life_st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        boot_cycle_o = 1'b0;
        wr_allow_o   = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                boot_cycle_o = 1'b1;
                state_d      = ST_ACTIVE;   // boot_done
            end
            ST_ACTIVE: begin
                wr_allow_o   = 1'b1;
                state_d      = ST_ACTIVE;   // hold_active
            end
            default: begin
                state_d      = ST_BOOT;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import pio_pkg::*;
#(
    parameter int           N         = 32,
    parameter logic [N-1:0] MODE_RST  = '0,
    parameter logic [N-1:0] DIR_RST   = '0,
    parameter logic [N-1:0] PULL_RST  = '0,
    parameter logic [N-1:0] LOCK_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         boot_cycle_i,
    input  logic         wr_allow_i,
    input  logic         strap_i,
    input  logic         wr_en_i,
    input  reg_sel_e     wr_sel_i,
    input  logic [N-1:0] wr_data_i,
    output logic [N-1:0] mode_o,
    output logic [N-1:0] dir_o,
    output logic [N-1:0] data_o,
    output logic [N-1:0] pull_o,
    output logic         lock_o
);

    logic [N-1:0] mode_q, dir_q, data_q, pull_q;
    logic         lock_q;
    logic [N-1:0] held_mask;

    // Pins that software may not touch once the strap lock is latched.
    assign held_mask = {N{lock_q}} & LOCK_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            dir_q  <= DIR_RST;
            pull_q <= PULL_RST;
            data_q <= '0;
            lock_q <= 1'b0;
        end else if (boot_cycle_i) begin
            lock_q <= ~strap_i;
            if (!strap_i) begin
                mode_q <= mode_q & ~LOCK_MASK;
            end
        end else if (wr_allow_i && wr_en_i) begin
            unique case (wr_sel_i)
                REG_MODE: mode_q <= wr_data_i & ~held_mask;
                REG_DIR:  dir_q  <= (wr_data_i & ~held_mask) | (dir_q & held_mask);
                REG_DATA: data_q <= wr_data_i;
                REG_PULL: pull_q <= wr_data_i;
                default: ;
            endcase
        end
    end

    assign mode_o = mode_q;
    assign dir_o  = dir_q;
    assign data_o = data_q;
    assign pull_o = pull_q;
    assign lock_o = lock_q;

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    logic [N-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
    parameter int           N        = 32,
    parameter logic [N-1:0] ISO_MASK = '0
) (
    input  logic         float_req_i,
    input  logic [N-1:0] mode_i,
    input  logic [N-1:0] dir_i,
    input  logic [N-1:0] data_i,
    input  logic [N-1:0] pull_i,
    input  logic [N-1:0] periph_out_i,
    input  logic [N-1:0] periph_oe_i,
    output logic [N-1:0] pad_out_o,
    output logic [N-1:0] pad_oe_o,
    output logic [N-1:0] pull_up_o,
    output logic [N-1:0] pull_dn_o
);

    for (genvar p = 0; p < N; p++) begin : g_pin
        logic in_mode;
        assign in_mode = mode_i[p] & ~dir_i[p];

        if (ISO_MASK[p]) begin : g_iso
            assign pad_oe_o[p] = mode_i[p] ? dir_i[p]
                                           : (periph_oe_i[p] & ~float_req_i);
        end else begin : g_plain
            assign pad_oe_o[p] = mode_i[p] ? dir_i[p] : periph_oe_i[p];
        end

        assign pad_out_o[p] = mode_i[p] ? data_i[p] : periph_out_i[p];
        assign pull_up_o[p] = in_mode &  pull_i[p];
        assign pull_dn_o[p] = in_mode & ~pull_i[p];
    end

endmodule

// File: rtl/pio_shared_ctrl.sv
module pio_shared_ctrl
    import pio_pkg::*;
#(
    parameter int           N         = 32,
    parameter int           SYNC_LEN  = 2,
    parameter logic [N-1:0] MODE_RST  = 32'h2000_FFC0,
    parameter logic [N-1:0] DIR_RST   = 32'h0000_0F00,
    parameter logic [N-1:0] PULL_RST  = 32'h2000_00C0,
    parameter logic [N-1:0] LOCK_MASK = 32'h8000_4000,
    parameter logic [N-1:0] ISO_MASK  = 32'h0007_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_i,
    input  logic         hold_i,
    input  logic         isolate_i,
    input  logic         wr_en_i,
    input  logic [2:0]   wr_addr_i,
    input  logic [N-1:0] wr_data_i,
    input  logic [2:0]   rd_addr_i,
    output logic [N-1:0] rd_data_o,
    input  logic [N-1:0] periph_out_i,
    input  logic [N-1:0] periph_oe_i,
    output logic [N-1:0] periph_in_o,
    input  logic [N-1:0] pad_in_i,
    output logic [N-1:0] pad_out_o,
    output logic [N-1:0] pad_oe_o,
    output logic [N-1:0] pull_up_o,
    output logic [N-1:0] pull_dn_o
);

    life_st_e     state_w;
    logic         boot_w, allow_w, lock_w;
    logic [N-1:0] mode_w, dir_w, data_w, pull_w, lvl_w;

    pio_life_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_o      (state_w),
        .boot_cycle_o (boot_w),
        .wr_allow_o   (allow_w)
    );

    pio_cfg_regs #(
        .N(N), .MODE_RST(MODE_RST), .DIR_RST(DIR_RST),
        .PULL_RST(PULL_RST), .LOCK_MASK(LOCK_MASK)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_cycle_i (boot_w),
        .wr_allow_i   (allow_w),
        .strap_i      (strap_i),
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (reg_sel_e'(wr_addr_i)),
        .wr_data_i    (wr_data_i),
        .mode_o       (mode_w),
        .dir_o        (dir_w),
        .data_o       (data_w),
        .pull_o       (pull_w),
        .lock_o       (lock_w)
    );

    pio_sync #(.N(N), .STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in_i),
        .sync_o  (lvl_w)
    );

    pio_pad_mux #(.N(N), .ISO_MASK(ISO_MASK)) u_mux (
        .float_req_i  (hold_i | isolate_i),
        .mode_i       (mode_w),
        .dir_i        (dir_w),
        .data_i       (data_w),
        .pull_i       (pull_w),
        .periph_out_i (periph_out_i),
        .periph_oe_i  (periph_oe_i),
        .pad_out_o    (pad_out_o),
        .pad_oe_o     (pad_oe_o),
        .pull_up_o    (pull_up_o),
        .pull_dn_o    (pull_dn_o)
    );

    assign periph_in_o = pad_in_i;

    always_comb begin
        unique case (reg_sel_e'(rd_addr_i))
            REG_MODE:  rd_data_o = mode_w;
            REG_DIR:   rd_data_o = dir_w;
            REG_DATA:  rd_data_o = data_w;
            REG_PULL:  rd_data_o = pull_w;
            REG_LEVEL: rd_data_o = lvl_w;
            default:   rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/pio_shared_ctrl_chk.sv
module pio_shared_ctrl_chk
    import pio_pkg::*;
#(
    parameter int           N         = 32,
    parameter logic [N-1:0] LOCK_MASK = '0,
    parameter logic [N-1:0] ISO_MASK  = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         hold_i,
    input logic         isolate_i,
    input life_st_e     state_w,
    input logic         lock_w,
    input logic [N-1:0] mode_w,
    input logic [N-1:0] dir_w,
    input logic [N-1:0] data_w,
    input logic [N-1:0] lvl_w,
    input logic [N-1:0] pad_in_i,
    input logic [N-1:0] pad_out_o,
    input logic [N-1:0] pad_oe_o,
    input logic [N-1:0] pull_up_o,
    input logic [N-1:0] pull_dn_o
);

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assert_pio_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_w & dir_w & (pad_out_o ^ data_w)) == '0) &&
        ((pad_oe_o & mode_w & dir_w) == (mode_w & dir_w)));

    assert_pull_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_up_o & pull_dn_o) == '0) &&
        (((pull_up_o | pull_dn_o) & ~(mode_w & ~dir_w)) == '0));

    assert_sync_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (lvl_w == $past(pad_in_i, 2)));

    assert_lock_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w |-> ((mode_w & LOCK_MASK) == '0));

    assert_lock_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_ACTIVE) |=> $stable(lock_w));

    assert_iso_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i || isolate_i) |-> ((pad_oe_o & ISO_MASK & ~mode_w) == '0));

    assert_boot_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_BOOT) |=> (state_w == ST_ACTIVE));

    assert_stay_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_ACTIVE) |=> (state_w == ST_ACTIVE));

endmodule

bind pio_shared_ctrl pio_shared_ctrl_chk #(
    .N(N), .LOCK_MASK(LOCK_MASK), .ISO_MASK(ISO_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (hold_i),
    .isolate_i (isolate_i),
    .state_w   (state_w),
    .lock_w    (lock_w),
    .mode_w    (mode_w),
    .dir_w     (dir_w),
    .data_w    (data_w),
    .lvl_w     (lvl_w),
    .pad_in_i  (pad_in_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o),
    .pull_up_o (pull_up_o),
    .pull_dn_o (pull_dn_o)
);

// File: tb/pio_shared_ctrl_tb.sv
module pio_shared_ctrl_tb_top;

    localparam logic [31:0] MODE_D = 32'h2000_FFC0;
    localparam logic [31:0] DIR_D  = 32'h0000_0F00;
    localparam logic [31:0] PULL_D = 32'h2000_00C0;
    localparam logic [31:0] LOCK   = 32'h8000_4000;
    localparam logic [31:0] ISO    = 32'h0007_0000;
    localparam logic [31:0] PERIPH = 32'hA5A5_5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_i = 1'b1, hold_i = 1'b0, isolate_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0, rd_addr_i = '0;
    logic [31:0] wr_data_i = '0, rd_data_o;
    logic [31:0] periph_out_i = PERIPH, periph_oe_i = '1, periph_in_o;
    logic [31:0] pad_in_i = '0, pad_out_o, pad_oe_o, pull_up_o, pull_dn_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pio_shared_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .hold_i(hold_i),
        .isolate_i(isolate_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .periph_out_i(periph_out_i), .periph_oe_i(periph_oe_i),
        .periph_in_o(periph_in_o), .pad_in_i(pad_in_i), .pad_out_o(pad_out_o),
        .pad_oe_o(pad_oe_o), .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr_i = a;
        #1 v = rd_data_o;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic do_reset(input logic strap, input bit wr_on_boot);
        @(negedge clk);
        rst_n = 1'b0; strap_i = strap;
        repeat (3) @(negedge clk);
        if (wr_on_boot) begin
            wr_en_i = 1'b1; wr_addr_i = 3'd2; wr_data_i = '1;
        end
        rst_n = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic t_defaults;
        logic [31:0] v;
        do_reset(1'b1, 1'b0);
        rd(3'd0, v); chk("R1 mode", v, MODE_D);
        rd(3'd1, v); chk("R1 dir", v, DIR_D);
        rd(3'd3, v); chk("R1 pull", v, PULL_D);
        rd(3'd2, v); chk("R1 data", v, 32'h0);
        chk("R2 oe29",   {31'h0, pad_oe_o[29]},  32'h0);
        chk("R2 pu29",   {31'h0, pull_up_o[29]}, 32'h1);
        chk("R2 pd29",   {31'h0, pull_dn_o[29]}, 32'h0);
        chk("R3 out periph", pad_out_o & ~MODE_D, PERIPH & ~MODE_D);
        chk("R3 oe periph",  pad_oe_o & ~MODE_D, ~MODE_D);
        chk("R3 boot pins",  pad_out_o & 32'h3F, PERIPH & 32'h3F);
    endtask

    task automatic t_boot_write;
        logic [31:0] v;
        do_reset(1'b1, 1'b1);
        rd(3'd2, v); chk("R10 boot write ignored", v, 32'h0);
        wr(3'd2, 32'h1234_5678);
        rd(3'd2, v); chk("R10 later write taken", v, 32'h1234_5678);
    endtask

    task automatic t_pio_output;
        do_reset(1'b1, 1'b0);
        wr(3'd2, 32'h0000_0500);
        chk("R4 pad out", pad_out_o & 32'h0F00, 32'h0500);
        chk("R4 pad oe",  pad_oe_o & 32'h0F00, 32'h0F00);
        wr(3'd2, 32'h0000_0A00);
        chk("R4 pad out flip", pad_out_o & 32'h0F00, 32'h0A00);
    endtask

    task automatic t_pio_input_pull;
        do_reset(1'b1, 1'b0);
        chk("R5 pull up default", pull_up_o, 32'h2000_00C0);
        chk("R5 pull dn default", pull_dn_o, 32'h0000_F000);
        chk("R5 input oe", pad_oe_o & 32'h2000_F0C0, 32'h0);
        wr(3'd3, 32'h0000_0000);
        chk("R5 pull dn after write", pull_dn_o, 32'h2000_F0C0);
        chk("R5 pull up after write", pull_up_o, 32'h0);
    endtask

    task automatic t_sync;
        logic [31:0] v;
        do_reset(1'b1, 1'b0);
        @(negedge clk);
        pad_in_i = 32'h2000_0000;
        rd(3'd4, v); chk("R6 before edge", v, 32'h0);
        @(negedge clk);
        rd(3'd4, v); chk("R6 after one edge", v, 32'h0);
        @(negedge clk);
        rd(3'd4, v); chk("R6 after two edges", v, 32'h2000_0000);
        chk("R6 periph raw", periph_in_o, 32'h2000_0000);
        pad_in_i = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_lock;
        logic [31:0] v;
        do_reset(1'b0, 1'b0);
        rd(3'd0, v); chk("R7 mode after lock", v, MODE_D & ~LOCK);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R7 mode write masked", v, ~LOCK);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v); chk("R7 dir write masked", v, ~LOCK);
        chk("R7 locked out", pad_out_o & LOCK, PERIPH & LOCK);
        chk("R7 locked oe",  pad_oe_o & LOCK, LOCK);
        strap_i = 1'b1;
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R7 strap change ignored", v, ~LOCK);
    endtask

    task automatic t_unlock;
        logic [31:0] v;
        do_reset(1'b1, 1'b0);
        rd(3'd0, v); chk("R8 mode kept", v, MODE_D);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R8 mode write all", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_float;
        do_reset(1'b1, 1'b0);
        @(negedge clk);
        hold_i = 1'b1;
        #1 chk("R9 hold iso", pad_oe_o & ISO, 32'h0);
        chk("R9 hold others", pad_oe_o & 32'h3F, 32'h3F);
        hold_i = 1'b0; isolate_i = 1'b1;
        #1 chk("R9 isolate iso", pad_oe_o & ISO, 32'h0);
        isolate_i = 1'b0;
        #1 chk("R9 released", pad_oe_o & ISO, ISO);
    endtask

    task automatic t_map;
        logic [31:0] v;
        do_reset(1'b1, 1'b0);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, v); chk("R11 level write ignored", v, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R11 mode untouched", v, MODE_D);
        rd(3'd1, v); chk("R11 dir untouched", v, DIR_D);
        rd(3'd2, v); chk("R11 data untouched", v, 32'h0);
        rd(3'd3, v); chk("R11 pull untouched", v, PULL_D);
        rd(3'd5, v); chk("R11 rsv5 zero", v, 32'h0);
        rd(3'd6, v); chk("R11 rsv6 zero", v, 32'h0);
        rd(3'd7, v); chk("R11 rsv7 zero", v, 32'h0);
    endtask

    initial begin
        t_defaults();
        t_boot_write();
        t_pio_output();
        t_pio_input_pull();
        t_sync();
        t_lock();
        t_unlock();
        t_float();
        t_map();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule